// File: doc/BRIEF.md
# Fall-Through FIFO with Programmable Watermark Flag

This block is a 2048-word by 9-bit first-in first-out buffer. Both of its strobe ports are sampled in a single clock domain. A word that enters an empty buffer is presented on the read data output in the cycle after it is written, with no read needed. A read strobe then advances the buffer to the next word. The block drives four status outputs:

- an active-low full flag;
- an active-low empty flag;
- a half-full flag;
- one watermark flag that signals both the near-empty and the near-full condition.

The two watermark levels are loaded through the write port during a short window after reset. The low level is X and the high offset is Y. Each value is 10 bits wide: the 9 data bits plus one extra input that serves as the most significant bit. If the window closes with no programming, both levels stay at 256.

An output-enable input gates only the data output. When it is low, the data output reads zero and the valid output is low. Output enable has no effect on the flags or on the buffer contents.

Top module: `fifo_ft_prog`

## Requirements
- R1: The buffer holds up to 2048 words and returns them in write order. A write strobe while the buffer is full changes neither the contents nor the flags. A read strobe while the buffer is empty has no effect.
- R2: `full_n` is 0 exactly when 2048 words are held. `empty_n` is 0 exactly when no word is held. Both flags reflect the occupancy after the latest clock edge.
- R3: `half_full` is 1 when 1024 or more words are held, and 0 when 1023 or fewer are held.
- R4: `wmark` is 1 when the occupancy is at most X or at least 2048 minus Y. It is 0 when the occupancy lies from X+1 through 2047 minus Y.
- R5: If no programming edge happens after reset, X and Y are both 256.
- R6: While the programming window is open, the first edge with `wr_stb`=1 and `prog_n`=0 loads {`wr_msb`,`wr_data`} into both X and Y. No word is stored on that edge, and the buffer stays empty.
- R7: Every later edge inside the window with `wr_stb`=1 and `prog_n`=0 loads {`wr_msb`,`wr_data`} into Y only. No word is stored on such an edge.
- R8: The window closes at the first edge where `wr_stb`=1 and `prog_n`=1, and the word on that edge is stored. After the window has closed, `prog_n` has no effect and every write strobe is a normal write.
- R9: While `rst` is high at a clock edge, the buffer is emptied and the flags become `full_n`=1, `empty_n`=0, `half_full`=0 and `wmark`=1. The programming window reopens with X=Y=256.
- R10: A word written into an empty buffer appears on `rd_data`, and `empty_n` goes to 1, one clock after the write edge, without any read.
- R11: When `out_en`=0, `rd_data` is 0 and `rd_valid` is 0, and the flags are unaffected. When `out_en`=1, `rd_valid` equals `empty_n`.
- R12: When a write and a read are both accepted on one edge, the occupancy is unchanged. On a full buffer, only the read of a simultaneous pair is accepted. On an empty buffer, only the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write strobe (also the programming strobe inside the window) |
| wr_data | input | 9 | Write data, and the low 9 bits of a watermark value |
| wr_msb | input | 1 | Most significant bit of a watermark value |
| prog_n | input | 1 | Programming request, active low |
| rd_stb | input | 1 | Read strobe, advances to the next word |
| out_en | input | 1 | Data output enable |
| rd_data | output | 9 | Oldest held word, or zero when output enable is low |
| rd_valid | output | 1 | Data output enabled and holding a word |
| full_n | output | 1 | Low when full |
| empty_n | output | 1 | Low when empty |
| half_full | output | 1 | High at or above half occupancy |
| wmark | output | 1 | Near-empty or near-full watermark flag |

## Verification
A corrupted occupancy count appears on the flags at the first edge where the count crosses a threshold. The 1024 boundary, the X and X+1 boundaries and the 2048-Y boundary each expose such an error within one clock, so the bench walks the occupancy through every one of these boundaries. A read pointer off by one, or a missed bypass on a write into an empty buffer, shows on `rd_data` in the next cycle, because the head word is compared on every cycle in which the output is enabled. A programming edge that stores a word, or that writes the wrong watermark register, shows either as `empty_n` rising during the window or as `wmark` flipping at the wrong occupancy later in the run.

// File: rtl/fifo_ft_pkg.sv
`timescale 1ns/1ps
package fifo_ft_pkg;
  // Registered status flags, sampled together
  typedef struct packed {
    logic full_n;
    logic empty_n;
    logic half;
    logic wmark;
  } fifo_flags_t;

  localparam fifo_flags_t FLAGS_RESET = '{full_n: 1'b1, empty_n: 1'b0, half: 1'b0, wmark: 1'b1};
endpackage

// File: rtl/fifo_thr_prog.sv
`timescale 1ns/1ps
// Watermark level registers and post-reset programming window
module fifo_thr_prog #(
  parameter int TW  = 10,
  parameter int DEF = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic          prog_n,
  input  logic [TW-1:0] value,
  output logic          win_open,
  output logic          prog_edge,
  output logic [TW-1:0] thr_lo,
  output logic [TW-1:0] thr_hi
);
  logic first_pend;

  assign prog_edge = win_open && wr_stb && !prog_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open   <= 1'b1;
      first_pend <= 1'b1;
      thr_lo     <= TW'(DEF);
      thr_hi     <= TW'(DEF);
    end else if (win_open && wr_stb) begin
      if (!prog_n) begin
        thr_hi <= value;
        if (first_pend) begin
          thr_lo     <= value;
          first_pend <= 1'b0;
        end
      end else begin
        win_open <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fifo_occ_ctrl.sv
`timescale 1ns/1ps
// Pointers, occupancy count and registered flags
module fifo_occ_ctrl
  import fifo_ft_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int TW    = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [TW-1:0] thr_lo,
  input  logic [TW-1:0] thr_hi,
  output logic          wr_acc,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] head_addr,
  output logic          bypass,
  output fifo_flags_t   flags
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [CW-1:0] HALFV = CW'(DEPTH / 2);

  logic [CW-1:0] cnt, cnt_nxt;
  logic [AW-1:0] rptr;
  logic          rd_acc;
  fifo_flags_t   flags_nxt;

  // Full refuses writes, empty refuses reads, independently of the other port
  assign wr_acc = wr_req && (cnt != FULLV);
  assign rd_acc = rd_req && (cnt != '0);

  assign head_addr = rd_acc ? rptr + AW'(1) : rptr;
  // The next head is the word written on this edge
  assign bypass = wr_acc && ((cnt == '0) || ((cnt == CW'(1)) && rd_acc));

  always_comb begin
    cnt_nxt = cnt;
    if (wr_acc && !rd_acc)      cnt_nxt = cnt + CW'(1);
    else if (!wr_acc && rd_acc) cnt_nxt = cnt - CW'(1);
  end

  always_comb begin
    flags_nxt.full_n  = (cnt_nxt != FULLV);
    flags_nxt.empty_n = (cnt_nxt != '0);
    flags_nxt.half    = (cnt_nxt >= HALFV);
    flags_nxt.wmark   = (cnt_nxt <= CW'(thr_lo)) || (cnt_nxt >= FULLV - CW'(thr_hi));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      wptr  <= '0;
      rptr  <= '0;
      flags <= FLAGS_RESET;
    end else begin
      cnt   <= cnt_nxt;
      flags <= flags_nxt;
      if (wr_acc) wptr <= wptr + AW'(1);
      if (rd_acc) rptr <= rptr + AW'(1);
    end
  end
endmodule

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
// Word storage with a registered head-of-buffer output and a write bypass
module fifo_store #(
  parameter int DEPTH = 2048,
  parameter int W     = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  input  logic          bypass,
  output logic [W-1:0]  head
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    head <= bypass ? wdata : mem[raddr];
  end
endmodule

// File: rtl/fifo_ft_prog.sv
`timescale 1ns/1ps
module fifo_ft_prog
  import fifo_ft_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         wr_msb,
  input  logic         prog_n,
  input  logic         rd_stb,
  input  logic         out_en,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         full_n,
  output logic         empty_n,
  output logic         half_full,
  output logic         wmark
);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = W + 1;

  logic          win_open, prog_edge, wr_acc, bypass;
  logic [TW-1:0] thr_lo, thr_hi;
  logic [AW-1:0] wptr, head_addr;
  logic [W-1:0]  head;
  fifo_flags_t   flags;

  fifo_thr_prog #(.TW(TW), .DEF(DEPTH / 8)) i_thr (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .prog_n(prog_n),
    .value({wr_msb, wr_data}), .win_open(win_open), .prog_edge(prog_edge),
    .thr_lo(thr_lo), .thr_hi(thr_hi)
  );

  fifo_occ_ctrl #(.DEPTH(DEPTH), .TW(TW)) i_ctrl (
    .clk(clk), .rst(rst), .wr_req(wr_stb && !prog_edge), .rd_req(rd_stb),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .wr_acc(wr_acc), .wptr(wptr),
    .head_addr(head_addr), .bypass(bypass), .flags(flags)
  );

  fifo_store #(.DEPTH(DEPTH), .W(W)) i_store (
    .clk(clk), .we(wr_acc), .waddr(wptr), .wdata(wr_data),
    .raddr(head_addr), .bypass(bypass), .head(head)
  );

  assign rd_data   = out_en ? head : '0;
  assign rd_valid  = out_en && flags.empty_n;
  assign full_n    = flags.full_n;
  assign empty_n   = flags.empty_n;
  assign half_full = flags.half;
  assign wmark     = flags.wmark;
endmodule

// File: rtl/fifo_ft_prog_chk.sv
`timescale 1ns/1ps
module fifo_ft_prog_chk (
  input logic clk,
  input logic rst,
  input logic wr_stb,
  input logic rd_stb,
  input logic prog_n,
  input logic win_open,
  input logic full_n,
  input logic empty_n,
  input logic half_full,
  input logic wmark
);
  logic store_edge;
  assign store_edge = wr_stb && !(win_open && !prog_n);

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (!full_n && wr_stb && !rd_stb) |=> !full_n);

  a_r1_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && rd_stb && !wr_stb) |=> !empty_n);

  a_r3_half_vs_ends: assert property (@(posedge clk) disable iff (rst)
    (!empty_n |-> !half_full) and (!full_n |-> half_full));

  a_r6_prog_no_store: assert property (@(posedge clk) disable iff (rst)
    (win_open && wr_stb && !prog_n) |=> !empty_n);

  a_r8_close_stores: assert property (@(posedge clk) disable iff (rst)
    (win_open && wr_stb && prog_n) |=> empty_n);

  a_r9_reset_flags: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (full_n && !empty_n && !half_full && wmark));

  a_r10_fall_through: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && store_edge) |=> empty_n);

  a_r12_pair_holds: assert property (@(posedge clk) disable iff (rst)
    (full_n && empty_n && wr_stb && rd_stb) |=>
      ($stable(full_n) && $stable(empty_n) && $stable(half_full) && $stable(wmark)));
endmodule

bind fifo_ft_prog fifo_ft_prog_chk i_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .prog_n(prog_n),
  .win_open(win_open), .full_n(full_n), .empty_n(empty_n),
  .half_full(half_full), .wmark(wmark)
);

// File: tb/test_fifo_ft_prog.sv
`timescale 1ns/1ps
module test_fifo_ft_prog;
  localparam int DEPTH = 2048;
  localparam int W     = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 0, wr_msb = 0, prog_n = 1, rd_stb = 0, out_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, full_n, empty_n, half_full, wmark;

  int errs = 0;
  int nchk = 0;

  // Reference model
  int m_cnt, m_x, m_y;
  bit m_win, m_first, m_oe;
  logic [W-1:0] mq[$];

  always #2 clk = ~clk;

  fifo_ft_prog #(.DEPTH(DEPTH), .W(W)) i_fifo_ft_prog (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .wr_msb(wr_msb),
    .prog_n(prog_n), .rd_stb(rd_stb), .out_en(out_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .full_n(full_n), .empty_n(empty_n),
    .half_full(half_full), .wmark(wmark)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_wmark(input int c);
    return (c <= m_x) || (c >= DEPTH - m_y);
  endfunction

  task automatic check_all();
    chk(full_n == (m_cnt != DEPTH), "R2 full_n", full_n, m_cnt != DEPTH);
    chk(empty_n == (m_cnt != 0), "R2 empty_n", empty_n, m_cnt != 0);
    chk(half_full == (m_cnt >= DEPTH / 2), "R3 half_full", half_full, m_cnt >= DEPTH / 2);
    chk(wmark == exp_wmark(m_cnt), "R4 wmark", wmark, exp_wmark(m_cnt));
    chk(rd_valid == (m_oe && m_cnt != 0), "R11 rd_valid", rd_valid, m_oe && m_cnt != 0);
    if (!m_oe) chk(rd_data == '0, "R11 gated data", rd_data, 0);
    else if (m_cnt > 0) chk(rd_data == mq[0], "R1 head order", rd_data, mq[0]);
  endtask

  // Called at a falling edge; returns at the next falling edge after checking
  task automatic step(input bit wr, input bit rd, input logic [W:0] v, input bit pn, input bit oe);
    bit prog, wa, ra;
    wr_stb = wr; rd_stb = rd; {wr_msb, wr_data} = v; prog_n = pn; out_en = oe; m_oe = oe;
    prog = m_win && wr && !pn;
    wa = wr && !prog && (m_cnt < DEPTH);
    ra = rd && (m_cnt > 0);
    @(posedge clk);
    if (prog) begin
      if (m_first) begin m_x = int'(v); m_first = 0; end
      m_y = int'(v);
    end else if (m_win && wr) m_win = 0;
    if (ra) void'(mq.pop_front());
    if (wa) mq.push_back(v[W-1:0]);
    m_cnt = mq.size();
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_stb = 0; rd_stb = 0; prog_n = 1; out_en = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    mq.delete(); m_cnt = 0; m_x = DEPTH / 8; m_y = DEPTH / 8; m_win = 1; m_first = 1; m_oe = 0;
    // R9 reset state
    chk(full_n == 1, "R9 full_n", full_n, 1);
    chk(empty_n == 0, "R9 empty_n", empty_n, 0);
    chk(half_full == 0, "R9 half_full", half_full, 0);
    chk(wmark == 1, "R9 wmark", wmark, 1);
  endtask

  task automatic fill_to(input int target, input bit pn);
    while (m_cnt < target) step(1, 0, {1'b0, W'($urandom)}, pn, 1);
  endtask

  task automatic drain_to(input int target);
    while (m_cnt > target) step(0, 1, '0, 1, 1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();

    // Default watermark levels (R5)
    step(0, 1, '0, 1, 1);                       // read on empty: ignored (R1)
    chk(empty_n == 0, "R1 empty read", empty_n, 0);
    step(1, 0, 10'h0A5, 1, 1);                  // closes the window, stores word (R8, R10)
    chk(empty_n == 1 && rd_data == 9'h0A5, "R10 fall-through", rd_data, 9'h0A5);
    fill_to(256, 1);  chk(wmark == 1, "R5 wmark at 256", wmark, 1);
    fill_to(257, 1);  chk(wmark == 0, "R5 wmark at 257", wmark, 0);
    fill_to(1023, 1); chk(half_full == 0, "R3 at 1023", half_full, 0);
    fill_to(1024, 1); chk(half_full == 1, "R3 at 1024", half_full, 1);
    fill_to(1791, 1); chk(wmark == 0, "R5 wmark at 1791", wmark, 0);
    fill_to(1792, 1); chk(wmark == 1, "R5 wmark at 1792", wmark, 1);
    fill_to(DEPTH, 0);                          // prog_n low after close: normal writes (R8)
    chk(full_n == 0, "R2 full", full_n, 0);
    begin
      logic [W-1:0] h;
      h = rd_data;
      step(1, 0, 10'h155, 1, 1);                // write while full ignored (R1)
      chk(full_n == 0 && rd_data == h, "R1 full write", rd_data, h);
    end
    step(1, 1, 10'h0F0, 1, 1);                  // R12: full pair, only read accepted
    chk(full_n == 1 && m_cnt == DEPTH - 1, "R12 full pair", full_n, 1);
    step(1, 1, 10'h0F1, 1, 1);                  // R12: accepted pair keeps occupancy
    chk(full_n == 1, "R12 pair holds", full_n, 1);
    drain_to(0);
    step(1, 1, 10'h13C, 1, 1);                  // R12: empty pair, only write accepted
    chk(empty_n == 1 && rd_data == 9'h13C, "R12 empty pair", rd_data, 9'h13C);
    drain_to(0);

    // Programmed levels: X=Y=20, then Y=30, then Y=40 (R6, R7)
    do_reset();
    step(1, 0, 10'd20, 0, 1);
    chk(empty_n == 0, "R6 program edge stores nothing", empty_n, 0);
    step(1, 0, 10'd30, 0, 1);
    step(1, 1, 10'd40, 0, 1);
    chk(empty_n == 0, "R7 program edge stores nothing", empty_n, 0);
    step(1, 0, 10'h011, 1, 1);                  // closes window (R8)
    chk(empty_n == 1 && rd_data == 9'h011, "R8 closing write stored", rd_data, 9'h011);
    step(1, 0, 10'h0C3, 0, 1);                  // prog_n low now ignored (R8)
    step(0, 1, '0, 1, 1);
    chk(rd_data == 9'h0C3, "R8 later write stored", rd_data, 9'h0C3);
    fill_to(20, 1);   chk(wmark == 1, "R6 wmark at X", wmark, 1);
    fill_to(21, 1);   chk(wmark == 0, "R6 wmark at X+1", wmark, 0);
    fill_to(2007, 1); chk(wmark == 0, "R7 wmark at 2007", wmark, 0);
    fill_to(2008, 1); chk(wmark == 1, "R7 wmark at 2008", wmark, 1);
    fill_to(DEPTH, 1);
    drain_to(1000);

    // Random traffic with shifting bias and output enable (R1, R11, R12)
    for (int ph = 0; ph < 6; ph++) begin
      int wb;
      wb = (ph % 2 == 0) ? 70 : 30;
      for (int i = 0; i < 800; i++)
        step(($urandom % 100) < wb, ($urandom % 100) < (100 - wb),
             10'($urandom), 1'($urandom), ($urandom % 8) != 0);
    end
    drain_to(0);
    step(0, 0, '0, 1, 0);
    chk(rd_data == '0 && rd_valid == 0 && empty_n == 0, "R11 disabled output", rd_data, 0);
    finish_run();
  end
endmodule